// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit accumulator. The accumulator is kept as two 32-bit words, a high word and a low word, and each word can be read and written directly. There are two operation widths. The long form multiplies full 32-bit operands. The word form multiplies only the signed low 16 bits of each operand. A start strobe launches one operation. The updated accumulator and a one-cycle done pulse appear on the cycle after the strobe.

A saturation-mode input changes how each width handles overflow. With saturation on, a long operation confines the high word to a 48-bit signed window. With saturation on, a word operation clamps the low word to the signed 32-bit range and sets the high word to 1. That 1 then stays in place as a sticky overflow mark; the accumulator no longer holds a true 64-bit sum. With saturation off, both widths keep the plain wrapped 64-bit sum. A clear input zeroes the whole accumulator.

Top module: `sat_mac`

## Requirements
- R1: After reset, both accumulator words read zero and done is low.
- R2: With op_word = 0 (long form), both 32-bit operands are taken as signed, and their full signed 64-bit product is added to {acc_hi, acc_lo}.
- R3: With op_word = 1 (word form), only bits 15:0 of each operand are used, as signed 16-bit values, and the product is sign-extended to 64 bits before the add. Bits 31:16 of the operands have no effect.
- R4: With sat_en = 0, either form writes the wrapped 64-bit sum back, high half to acc_hi and low half to acc_lo.
- R5: With sat_en = 1, a long form whose 64-bit sum is negative writes acc_hi with bits 31:16 forced to ones and bits 15:0 taken from the sum. acc_lo is taken from the sum.
- R6: With sat_en = 1, a long form whose sum is non-negative writes acc_hi with bits 31:15 cleared and bits 14:0 taken from the sum. acc_lo is taken from the sum.
- R7: With sat_en = 1, a word form whose sum exceeds 2^31-1 writes acc_lo = 0x7FFFFFFF and acc_hi = 1. A later saturating word operation on that state saturates again.
- R8: With sat_en = 1, a word form whose sum is below -2^31 writes acc_lo = 0x80000000 and acc_hi = 1.
- R9: With sat_en = 1, a word form whose sum lies within the signed 32-bit range writes the plain sum.
- R10: clr zeroes both words at the next edge. It takes priority over start and over the direct writes in the same cycle.
- R11: hi_we / lo_we load hi_wdata / lo_wdata into the matching word at the next edge, each independently of the other. A direct write is ignored in a cycle where start is high.
- R12: done is high for exactly the one cycle after each start. Without start, clr or a write, both words hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one multiply-accumulate |
| op_word | input | 1 | 0 = long form, 1 = word form |
| sat_en | input | 1 | Saturation mode |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr | input | 1 | Zero the accumulator |
| hi_we | input | 1 | Write enable, high word |
| hi_wdata | input | 32 | Write data, high word |
| lo_we | input | 1 | Write enable, low word |
| lo_wdata | input | 32 | Write data, low word |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| done | output | 1 | One-cycle pulse after start |

## Verification
The bench builds the unit with its default widths, a 32-bit data word and a 16-bit narrow operand. At these widths every product and sum fits in a 64-bit integer of the bench, so the expected accumulator comes from plain integer arithmetic with no modelling of bit slices. Direct writes of the high and low words preload values just inside and just outside the ±2^31 limits and the 48-bit window. This puts both saturation directions of each form, and the sticky high word, within a handful of cycles. Random operands drawn from extreme, small and 16-bit edge values then mix all four mode combinations with clears and writes.

// File: rtl/sat_mac_pkg.sv
`timescale 1ns/1ps
package sat_mac_pkg;

  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } op_kind_e;

endpackage

// File: rtl/sat_mac_prod.sv
`timescale 1ns/1ps
module sat_mac_prod
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  op_kind_e               kind,
  input  logic [DATA_W-1:0]      op_a,
  input  logic [DATA_W-1:0]      op_b,
  output logic [2*DATA_W-1:0]    prod
);
  localparam int ACC_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] mul_long(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] ye;
    xe = {{DATA_W{x[DATA_W-1]}}, x};
    ye = {{DATA_W{y[DATA_W-1]}}, y};
    return xe * ye;
  endfunction

  function automatic logic [ACC_W-1:0] mul_narrow(logic [HALF_W-1:0] x, logic [HALF_W-1:0] y);
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] ye;
    xe = {{(ACC_W-HALF_W){x[HALF_W-1]}}, x};
    ye = {{(ACC_W-HALF_W){y[HALF_W-1]}}, y};
    return xe * ye;
  endfunction

  logic [ACC_W-1:0] p_long;
  logic [ACC_W-1:0] p_word;

  assign p_long = mul_long(op_a, op_b);

  generate
    if (HALF_W < DATA_W) begin : g_narrow
      assign p_word = mul_narrow(op_a[HALF_W-1:0], op_b[HALF_W-1:0]);
    end else begin : g_full
      assign p_word = p_long;
    end
  endgenerate

  assign prod = (kind == OP_WORD) ? p_word : p_long;
endmodule

// File: rtl/sat_mac_sat.sv
`timescale 1ns/1ps
module sat_mac_sat
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_kind_e               kind,
  input  logic                   sat_en,
  input  logic [2*DATA_W-1:0]    acc,
  input  logic [2*DATA_W-1:0]    prod,
  output logic [2*DATA_W-1:0]    sum,
  output logic                   word_over_pos,
  output logic                   word_over_neg,
  output logic [2*DATA_W-1:0]    result
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int SET_W  = DATA_W / 2;
  localparam int KEEP_W = SET_W - 1;
  localparam logic [DATA_W-1:0] LO_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] LO_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] HI_ONE = DATA_W'(1);

  function automatic logic [ACC_W-1:0] sat_long(logic [ACC_W-1:0] s);
    logic [DATA_W-1:0] hi;
    hi = s[ACC_W-1:DATA_W];
    if (s[ACC_W-1]) hi[DATA_W-1:DATA_W-SET_W] = '1;
    else            hi[DATA_W-1:KEEP_W]       = '0;
    return {hi, s[DATA_W-1:0]};
  endfunction

  function automatic logic [ACC_W-1:0] sat_word(logic [ACC_W-1:0] s, logic pos, logic neg);
    if (pos) return {HI_ONE, LO_MAX};
    if (neg) return {HI_ONE, LO_MIN};
    return s;
  endfunction

  logic [DATA_W:0] upper;

  assign sum   = acc + prod;
  assign upper = sum[ACC_W-1:DATA_W-1];
  assign word_over_pos = !sum[ACC_W-1] && (|upper);
  assign word_over_neg =  sum[ACC_W-1] && !(&upper);

  always_comb begin
    if (!sat_en)              result = sum;
    else if (kind == OP_WORD) result = sat_word(sum, word_over_pos, word_over_neg);
    else                      result = sat_long(sum);
  end
endmodule

// File: rtl/sat_mac_acc.sv
`timescale 1ns/1ps
module sat_mac_acc #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                load,
  input  logic [2*DATA_W-1:0] load_val,
  input  logic                hi_we,
  input  logic [DATA_W-1:0]   hi_wdata,
  input  logic                lo_we,
  input  logic [DATA_W-1:0]   lo_wdata,
  output logic [DATA_W-1:0]   acc_hi,
  output logic [DATA_W-1:0]   acc_lo,
  output logic                done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= load;
      if (clr) begin
        acc_hi <= '0;
        acc_lo <= '0;
      end else if (load) begin
        acc_hi <= load_val[2*DATA_W-1:DATA_W];
        acc_lo <= load_val[DATA_W-1:0];
      end else begin
        if (hi_we) acc_hi <= hi_wdata;
        if (lo_we) acc_lo <= lo_wdata;
      end
    end
  end
endmodule

// File: rtl/sat_mac.sv
`timescale 1ns/1ps
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_word,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              clr,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] hi_wdata,
  input  logic              lo_we,
  input  logic [DATA_W-1:0] lo_wdata,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo,
  output logic              done
);
  localparam int ACC_W = 2 * DATA_W;

  op_kind_e         kind;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] result;
  logic             word_over_pos;
  logic             word_over_neg;

  assign kind = op_kind_e'(op_word);

  sat_mac_prod #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prod (
    .kind (kind),
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
  );

  sat_mac_sat #(.DATA_W(DATA_W)) u_sat (
    .kind          (kind),
    .sat_en        (sat_en),
    .acc           ({acc_hi, acc_lo}),
    .prod          (prod),
    .sum           (sum),
    .word_over_pos (word_over_pos),
    .word_over_neg (word_over_neg),
    .result        (result)
  );

  sat_mac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (start),
    .load_val (result),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .lo_wdata (lo_wdata),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo),
    .done     (done)
  );
endmodule

// File: rtl/sat_mac_chk.sv
`timescale 1ns/1ps
module sat_mac_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                op_word,
  input logic                sat_en,
  input logic                clr,
  input logic                hi_we,
  input logic                lo_we,
  input logic [DATA_W-1:0]   acc_hi,
  input logic [DATA_W-1:0]   acc_lo,
  input logic                done,
  input logic [2*DATA_W-1:0] sum,
  input logic                word_over_pos,
  input logic                word_over_neg
);
  localparam int MSB = 2 * DATA_W - 1;
  localparam int HW  = DATA_W / 2;

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr && !sat_en |=> {acc_hi, acc_lo} == $past(sum));

  assert_long_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr && !op_word && sat_en && sum[MSB] |=> acc_hi[DATA_W-1:HW] == '1);

  assert_long_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr && !op_word && sat_en && !sum[MSB] |=> acc_hi[DATA_W-1:HW-1] == '0);

  assert_word_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr && op_word && sat_en && word_over_pos |=>
      acc_hi == DATA_W'(1) && acc_lo == {1'b0, {(DATA_W-1){1'b1}}});

  assert_word_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr && op_word && sat_en && word_over_neg |=>
      acc_hi == DATA_W'(1) && acc_lo == {1'b1, {(DATA_W-1){1'b0}}});

  assert_one_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_over_pos, word_over_neg}));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_hi == '0 && acc_lo == '0);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !clr && !hi_we && !lo_we |=> $stable(acc_hi) && $stable(acc_lo));

  assert_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
endmodule

bind sat_mac sat_mac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .op_word       (op_word),
  .sat_en        (sat_en),
  .clr           (clr),
  .hi_we         (hi_we),
  .lo_we         (lo_we),
  .acc_hi        (acc_hi),
  .acc_lo        (acc_lo),
  .done          (done),
  .sum           (sum),
  .word_over_pos (word_over_pos),
  .word_over_neg (word_over_neg)
);

// File: tb/sim_sat_mac.sv
`timescale 1ns/1ps
module sim_sat_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0, clr = 1'b0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, hi_wdata = '0, lo_wdata = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int          checks = 0;
  int          errors = 0;
  logic [63:0] mdl = '0;

  always #2.5 clk = ~clk;

  sat_mac u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word), .sat_en(sat_en),
    .op_a(op_a), .op_b(op_b), .clr(clr), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  // Expected accumulator, worked out with 64-bit integers.
  function automatic logic [63:0] ref_mac(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                          bit w, bit s);
    longint p, t;
    longint lim_hi = 64'sd2147483647;
    longint lim_lo = -64'sd2147483648;
    if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else   p = longint'($signed(a)) * longint'($signed(b));
    t = longint'(acc) + p;
    if (s && w) begin
      if (t > lim_hi) return {32'd1, 32'h7FFF_FFFF};
      if (t < lim_lo) return {32'd1, 32'h8000_0000};
    end
    if (s && !w) begin
      if (t < 0) return t | 64'hFFFF_0000_0000_0000;
      return t & 64'h0000_7FFF_FFFF_FFFF;
    end
    return t;
  endfunction

  function automatic string tag_for(bit w, bit s);
    if (!s) return w ? "R3/R4" : "R2/R4";
    return w ? "R3/R7/R8/R9" : "R2/R5/R6";
  endfunction

  function automatic logic [31:0] pick_operand();
    case ($urandom % 5)
      0: return 32'($signed($urandom % 17) - 8);
      1: return $urandom;
      2: case ($urandom % 3)
           0: return 32'h8000_0000;
           1: return 32'h7FFF_FFFF;
           default: return 32'hFFFF_FFFF;
         endcase
      3: return {$urandom % 65536 == 0 ? 16'h0 : 16'($urandom), ($urandom % 2) ? 16'h8000 : 16'h7FFF};
      default: return {16'($urandom), 16'($urandom)};
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_mac(bit w, bit s, logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk);
    op_word = w; sat_en = s; op_a = a; op_b = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    mdl = ref_mac(mdl, a, b, w, s);
    chk(tag, {acc_hi, acc_lo}, mdl);
    chk({tag, " R12 done"}, 64'(done), 64'd1);
  endtask

  task automatic do_write(bit wh, bit wl, logic [31:0] hv, logic [31:0] lv);
    @(negedge clk);
    hi_we = wh; lo_we = wl; hi_wdata = hv; lo_wdata = lv;
    @(posedge clk); #1;
    hi_we = 1'b0; lo_we = 1'b0;
    if (wh) mdl[63:32] = hv;
    if (wl) mdl[31:0]  = lv;
    chk("R11 write", {acc_hi, acc_lo}, mdl);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    mdl = '0;
    chk("R10 clear", {acc_hi, acc_lo}, mdl);
  endtask

  task automatic do_idle();
    @(negedge clk);
    @(posedge clk); #1;
    chk("R12 hold", {acc_hi, acc_lo}, mdl);
    chk("R12 done low", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R4: plain signed products
    do_mac(1'b0, 1'b0, 32'hFFFF_FFFD, 32'd7, "R2 long neg");
    do_mac(1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, "R2 long min*min");
    do_idle();
    // R3: upper operand bits ignored
    do_clear();
    do_mac(1'b1, 1'b0, 32'hABCD_0003, 32'h1234_FFFE, "R3 word upper ignored");
    chk("R3 word -6", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFA);
    // R4: wrap without saturation
    do_write(1'b1, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    do_mac(1'b0, 1'b0, 32'd1, 32'd1, "R4 wrap");
    chk("R4 wrap value", {acc_hi, acc_lo}, 64'h8000_0000_0000_0000);
    // R5: long saturation negative
    do_write(1'b1, 1'b1, 32'h8001_2345, 32'd5);
    do_mac(1'b0, 1'b1, 32'd0, 32'd0, "R5 long sat neg");
    chk("R5 value", {acc_hi, acc_lo}, 64'hFFFF_2345_0000_0005);
    // R6: long saturation non-negative
    do_write(1'b1, 1'b1, 32'h0001_C123, 32'd9);
    do_mac(1'b0, 1'b1, 32'd0, 32'd0, "R6 long sat pos");
    chk("R6 value", {acc_hi, acc_lo}, 64'h0000_4123_0000_0009);
    // R7: word saturation above, then sticky
    do_write(1'b1, 1'b1, 32'd0, 32'h7FFF_FFF0);
    do_mac(1'b1, 1'b1, 32'd16, 32'd1, "R7 word sat pos");
    chk("R7 value", {acc_hi, acc_lo}, 64'h0000_0001_7FFF_FFFF);
    do_mac(1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1, "R7 sticky");
    chk("R7 sticky value", {acc_hi, acc_lo}, 64'h0000_0001_7FFF_FFFF);
    // R8: word saturation below
    do_write(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0005);
    do_mac(1'b1, 1'b1, 32'hFFFF_FFF0, 32'd1, "R8 word sat neg");
    chk("R8 value", {acc_hi, acc_lo}, 64'h0000_0001_8000_0000);
    // R9: in range
    do_write(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0010);
    do_mac(1'b1, 1'b1, 32'hFFFF_FFF0, 32'd1, "R9 word in range");
    chk("R9 value", {acc_hi, acc_lo}, 64'hFFFF_FFFF_8000_0000);
    // R11: independent writes; write ignored during start
    do_write(1'b1, 1'b0, 32'h1357_9BDF, 32'h0);
    do_write(1'b0, 1'b1, 32'h0, 32'h2468_ACE0);
    @(negedge clk);
    start = 1'b1; op_word = 1'b0; sat_en = 1'b0; op_a = 32'd2; op_b = 32'd3;
    hi_we = 1'b1; lo_we = 1'b1; hi_wdata = 32'hDEAD_BEEF; lo_wdata = 32'hCAFE_F00D;
    @(posedge clk); #1;
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    mdl = ref_mac(mdl, 32'd2, 32'd3, 1'b0, 1'b0);
    chk("R11 write ignored under start", {acc_hi, acc_lo}, mdl);
    // R10: clear beats start and writes
    @(negedge clk);
    clr = 1'b1; start = 1'b1; hi_we = 1'b1; lo_we = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0; start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    mdl = '0;
    chk("R10 clear priority", {acc_hi, acc_lo}, 64'd0);
    chk("R12 done with clear", 64'(done), 64'd1);
    do_idle();

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = $urandom % 20;
      if (sel < 13) begin
        bit w, s;
        w = 1'($urandom);
        s = 1'($urandom);
        do_mac(w, s, pick_operand(), pick_operand(), tag_for(w, s));
      end else if (sel < 16) begin
        do_write(1'($urandom), 1'($urandom), pick_operand(), pick_operand());
      end else if (sel < 17) begin
        do_clear();
      end else begin
        do_idle();
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule